// File: doc/BRIEF.md
# Edge/Level Interrupt Request Controller

This block takes eight interrupt request lines that are already synchronised to the core clock. It picks the most urgent request that is allowed to run and signals it to the processor. It then answers a two-pulse acknowledge handshake with a 3-bit vector index. Input 0 has the highest priority and input 7 the lowest.

Each input has three pieces of state:

- **Request bit.** While the input's arm flag is clear, this bit follows the request line in the same cycle.
- **Arm flag.** It is set when the input is acknowledged. In edge mode it forces the request bit low. It clears only once the line is low and the input is no longer in service.
- **In-service bit.** It marks an input that has been acknowledged and not yet retired.

A single-cycle end-of-interrupt strobe retires the highest-priority input that is in service. The choice of request is frozen when the first acknowledge pulse falls. If no request is eligible at that moment, the second pulse returns the lowest-priority index 7 as a spurious answer, and no in-service bit is set. A typical cause is a line that dropped before the first acknowledge pulse ended.

Top module: `irq_ctrl`

## Requirements
- R1: When the first acknowledge pulse falls, the controller selects the lowest-numbered unmasked pending request and sets its in-service bit. During the second pulse, `vec_oe` is 1 and `vec_idx` carries that input number.
- R2: An in-service bit is never cleared except by an `eoi` strobe.
- R3: In edge mode (`level_trig`=0), an input that has been acknowledged cannot raise `irq_out` again, even after `eoi`, while its line stays high. Once its line has been low with its in-service bit clear, a new rising level raises `irq_out` again.
- R4: `irq_out` is 1 exactly when some unmasked request is pending at an index p and no in-service bit at index p or lower is set. A `mask` bit of 1 hides its input.
- R5: An `eoi` strobe clears only the lowest-numbered set in-service bit. Other set bits keep blocking lower-priority requests.
- R6: In level mode (`level_trig`=1), a line still high after `eoi` raises `irq_out` again at once.
- R7: If no eligible request exists when the first acknowledge pulse falls, the second pulse returns index 7 and no in-service bit is set.
- R8: With no acknowledge, a request line that rises and then falls leaves `irq_out` low and leaves nothing pending.
- R9: After reset, `irq_out`, `vec_oe` and `vec_idx` are all 0.
- R10: A request line rising while its arm flag is clear drives `irq_out` high in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Synchronised request lines, bit 0 most urgent |
| mask | input | 8 | 1 hides the corresponding request |
| level_trig | input | 1 | 1 = level mode, 0 = edge mode |
| inta | input | 1 | Acknowledge pulses from the processor |
| eoi | input | 1 | One-cycle end-of-interrupt strobe |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_oe | output | 1 | High while the index is driven in the second pulse |
| vec_idx | output | 3 | Vector index, zero when not driven |

## Verification
Wrong in-service or arm state is never visible directly. It shows up as `irq_out` being wrongly low or high.

- An in-service bit that is stuck or cleared early changes whether a lower-priority request can raise `irq_out`. The bench probes this in the cycle after each `eoi` by raising such a request.
- An arm flag that is wrong shows up as `irq_out` re-raising, or failing to re-raise, for a held line once the input is retired.
- A wrong frozen choice shows up only in `vec_idx` during the second acknowledge pulse. A scoreboard queue compares that value against the index predicted at the moment the acknowledge was issued.

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int NUM_IRQ = 8,
  localparam int IDX_W = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [NUM_IRQ-1:0] mask,
  input  logic               level_trig,
  input  logic               inta,
  input  logic               eoi,
  output logic               irq_out,
  output logic               vec_oe,
  output logic [IDX_W-1:0]   vec_idx
);

  logic [NUM_IRQ-1:0] isr_q, arm_q, irr, req, retire, take;
  logic               inta_q, phase_q, best_vld, blocked, grant, freeze, done;
  logic [IDX_W-1:0]   best_idx, sel_q;

  assign irr = irq_in & ~(arm_q & {NUM_IRQ{~level_trig}});
  assign req = irr & ~mask;

  always_comb begin
    best_vld = 1'b0;
    best_idx = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--)
      if (req[i]) begin
        best_vld = 1'b1;
        best_idx = IDX_W'(i);
      end
    blocked = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (isr_q[i] && i <= int'(best_idx)) blocked = 1'b1;
  end

  assign grant   = best_vld & ~blocked;
  assign irq_out = grant;
  assign freeze  = inta_q & ~inta & ~phase_q;
  assign done    = inta_q & ~inta & phase_q;
  assign retire  = eoi ? (isr_q & (-isr_q)) : '0;
  assign take    = (freeze && grant) ? (NUM_IRQ'(1) << best_idx) : '0;
  assign vec_oe  = phase_q & inta;
  assign vec_idx = vec_oe ? sel_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q   <= '0;
      arm_q   <= '0;
      inta_q  <= 1'b0;
      phase_q <= 1'b0;
      sel_q   <= '0;
    end else begin
      inta_q <= inta;
      isr_q  <= (isr_q & ~retire) | take;
      arm_q  <= (arm_q & (irq_in | isr_q)) | take;
      if (freeze) begin
        phase_q <= 1'b1;
        sel_q   <= grant ? best_idx : IDX_W'(NUM_IRQ - 1);
      end else if (done) begin
        phase_q <= 1'b0;
      end
    end
  end

  AST_ISR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !eoi |=> ((isr_q & $past(isr_q)) == $past(isr_q))); // R2
  AST_EOI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> ($countones($past(isr_q) & ~isr_q) <= 1)); // R5
  AST_ARM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(arm_q) & ~arm_q & ($past(irq_in) | $past(isr_q))) == '0)); // R3
  AST_SPURIOUS_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !grant && !eoi) |=> (isr_q == $past(isr_q))); // R7
  AST_IRQ_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (|(irq_in & ~mask))); // R4
  AST_ONE_NEW_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(isr_q & ~$past(isr_q)) <= 1)); // R1

endmodule

// File: tb/irq_ctrl_test.sv
`timescale 1ns/1ps
module irq_ctrl_test;
  logic       clk = 1'b0, rst_n = 1'b0, level_trig = 1'b0, inta = 1'b0, eoi = 1'b0;
  logic [7:0] irq_in = '0, mask = '0;
  logic       irq_out, vec_oe;
  logic [2:0] vec_idx;
  int checks = 0, fails = 0;
  int    exp_q[$];
  string tag_q[$];
  logic  seen = 1'b0;

  irq_ctrl uut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask(mask),
    .level_trig(level_trig), .inta(inta), .eoi(eoi), .irq_out(irq_out),
    .vec_oe(vec_oe), .vec_idx(vec_idx));

  always #2 clk = ~clk;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset(input logic lvl);
    rst_n = 1'b0; irq_in = '0; mask = '0; inta = 1'b0; eoi = 1'b0; level_trig = lvl;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic probe(input int exp, input string tag);
    @(negedge clk);
    chk(int'(irq_out), exp, tag);
    #1;
  endtask

  task automatic ack(input int exp, input logic [7:0] drop, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    inta = 1'b1; step();
    irq_in = irq_in & ~drop; step();
    inta = 1'b0; step();
    inta = 1'b1; step();
    inta = 1'b0; step();
    step();
  endtask

  task automatic pulse_eoi();
    eoi = 1'b1; step();
    eoi = 1'b0; step();
  endtask

  always @(negedge clk) begin
    if (vec_oe && !seen) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R1 unexpected vector actual=%0d expected=none", vec_idx);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (int'(vec_idx) != e) begin
          fails++;
          $display("FAIL %s vector actual=%0d expected=%0d", t, vec_idx, e);
        end
      end
    end
    seen = vec_oe;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    @(negedge clk);
    chk(int'(irq_out), 0, "R9 irq_out");
    chk(int'(vec_oe), 0, "R9 vec_oe");
    chk(int'(vec_idx), 0, "R9 vec_idx");
    #1;
    // R10: same-cycle path from line to irq_out
    irq_in[5] = 1'b1;
    probe(1, "R10 comb path");
    irq_in[3] = 1'b1; step();
    ack(3, 8'h00, "R1 pick 3 over 5");
    probe(0, "R4 isr3 blocks 5");
    pulse_eoi();
    probe(1, "R3 line5 still eligible");
    ack(5, 8'h00, "R1 pick 5");
    pulse_eoi();
    probe(0, "R3 held lines stay armed");
    irq_in[3] = 1'b0; step(); step();
    irq_in[3] = 1'b1;
    probe(1, "R3 new edge after release");

    do_reset(1'b0);
    irq_in[4] = 1'b1; step();
    ack(4, 8'h00, "R1 pick 4");
    irq_in[1] = 1'b1;
    probe(1, "R4 1 outranks isr4");
    ack(1, 8'h00, "R1 nested 1");
    pulse_eoi();
    irq_in[6] = 1'b1;
    probe(0, "R5 isr4 still blocks 6");
    pulse_eoi();
    probe(1, "R5 second eoi frees 6");

    do_reset(1'b0);
    mask[2] = 1'b1; irq_in[2] = 1'b1;
    probe(0, "R4 masked");
    mask[2] = 1'b0;
    probe(1, "R4 unmasked");

    do_reset(1'b1);
    irq_in[2] = 1'b1; step();
    ack(2, 8'h00, "R1 level pick 2");
    probe(0, "R4 level in service");
    pulse_eoi();
    probe(1, "R6 level reasserts");

    do_reset(1'b0);
    irq_in[3] = 1'b1; step();
    ack(7, 8'h08, "R7 spurious index");
    probe(0, "R7 nothing pending");
    irq_in[7] = 1'b1;
    probe(1, "R7 no isr7 set");

    do_reset(1'b0);
    irq_in[6] = 1'b1;
    probe(1, "R8 rise");
    irq_in[6] = 1'b0; step(); step(); step();
    probe(0, "R8 no pending after fall");

    step(); step();
    chk(exp_q.size(), 0, "R1 all vectors seen");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule